// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block runs the external memory cycles of a small processor whose low address byte and data byte share one set of eight bus pins. On its internal side it accepts one request at a time over a valid/ready handshake. A request is an instruction fetch, a data read or a data write, with a 20-bit address and a write byte. The block answers with a one-cycle done pulse and, for reads, the byte it captured from the bus.

On the external side it drives the shared byte lane and its output enable, the upper address lines (bits 19..8), an address latch strobe, and three active-low strobes: one for program fetch, one for data read and one for data write. It also samples a wait input that stretches data cycles. One clock cycle equals one oscillator phase ("tick"), so every edge sits at a fixed tick offset.

A program-space select pin picks how fetches are decoded. When the pin is high, fetches below 0x10000 are internal and never reach the bus. When it is low, every fetch goes to the bus.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, reqReady is 1, ale is 0, psenN/rdN/wrN are 1, adOe is 0 and rspDone is 0.
- R2: A fetch (reqKind 2'b00) with progSel high and reqAddr[19:16] equal to 0 produces no bus activity. It is answered with rspDone and rspInternal high in the first tick after acceptance. With progSel low, every fetch runs a bus cycle.
- R3: ale is high for exactly two ticks. adOe is high and adOut carries reqAddr[7:0] in both of those ticks and in the one tick after ale falls.
- R4: The strobe that matches the kind goes low in the second tick after ale falls and stays low for two ticks when no wait is applied. The strobes are psenN for fetch (2'b00), rdN for read (2'b01, and 2'b11 is treated as a read) and wrN for write (2'b10). At most one strobe is low at a time.
- R5: addrHi takes reqAddr[19:8] in the first tick after acceptance. That gives four ticks of setup before the strobe on a fetch and three on a data access. addrHi is held through the tick after the strobe rises.
- R6: In a data access, waitIn high in the last strobe tick extends the strobe by one tick, and this repeats for each such tick. A fetch ignores waitIn.
- R7: In a write, adOe stays high and adOut carries the write byte from the first strobe tick through the tick after wrN rises.
- R8: In a read or fetch, adOe is low from the first strobe tick on. adIn is captured at the clock edge where the strobe rises. The captured byte appears on rspData during the single rspDone tick that follows.
- R9: reqReady is high only when no access is in progress. A reqValid pulse while reqReady is low starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one oscillator phase per cycle |
| rstN | input | 1 | Active-low synchronous reset |
| progSel | input | 1 | High: fetches below 0x10000 are internal; low: all fetches external |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle, request accepted this cycle |
| reqKind | input | 2 | 00 fetch, 01 read, 10 write, 11 read |
| reqAddr | input | 20 | Access address |
| reqWdata | input | 8 | Write byte |
| rspDone | output | 1 | One-tick completion pulse |
| rspInternal | output | 1 | Completion was an internal program-space hit |
| rspData | output | 8 | Captured read byte |
| adIn | input | 8 | Shared lane, input side |
| adOut | output | 8 | Shared lane, output side |
| adOe | output | 1 | Shared lane output enable |
| addrHi | output | 12 | Upper address lines 19..8 |
| ale | output | 1 | Address latch strobe, active high |
| psenN | output | 1 | Program fetch strobe, active low |
| rdN | output | 1 | Data read strobe, active low |
| wrN | output | 1 | Data write strobe, active low |
| waitIn | input | 1 | Stretch request for data cycles |

## Verification
Every bus access is recorded tick by tick and compared with a timeline built from the kind, the address and the wait count. Fetch, read and write are each run with distinct addresses and bytes. A mix-up of lanes, strobes or address halves therefore shows up as a wrong value, not a coincidence.

Fetches are issued on both sides of the 64 KiB boundary with the select pin high, and once with it low. These runs separate internal decode from external routing. Reads and writes are repeated with wait ticks, and a fetch is run with wait held high, to show that only data cycles stretch.

The read byte on the lane is valid only in the last strobe tick, so capture one tick early or late is caught. A request pulsed in mid-access confirms the handshake holds it off.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_READ  = 2'b01;
  localparam logic [1:0] KIND_WRITE = 2'b10;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_HISET,
    PH_ALE1,
    PH_ALE2,
    PH_LOHOLD,
    PH_STB1,
    PH_STB2,
    PH_RECOV,
    PH_INTACK
  } busPhase_t;

  typedef struct packed {
    logic latchReq;
    logic driveLo;
    logic driveWr;
    logic aleOn;
    logic psenOn;
    logic rdOn;
    logic wrOn;
    logic sampleRd;
    logic doneOn;
    logic internalOn;
  } busCtl_t;

endpackage

// File: rtl/mux_bus_fsm.sv
module mux_bus_fsm
  import mux_bus_pkg::*;
#(
  parameter int TOP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             progSel,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic [TOP_W-1:0] reqAddrTop,
  input  logic             waitIn,
  output logic             reqReady,
  output busCtl_t          ctl
);

  busPhase_t phase, phaseNext;
  logic [1:0] kindQ;
  logic isFetchQ, isWriteQ, isDataQ, stretch, isIntReq;

  assign isFetchQ = (kindQ == KIND_FETCH);
  assign isWriteQ = (kindQ == KIND_WRITE);
  assign isDataQ  = !isFetchQ;
  assign stretch  = isDataQ && waitIn;
  assign isIntReq = (reqKind == KIND_FETCH) && progSel && (reqAddrTop == '0);

  assign reqReady = (phase == PH_IDLE);

  always_comb begin
    phaseNext = phase;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          if (isIntReq)                    phaseNext = PH_INTACK;
          else if (reqKind == KIND_FETCH)  phaseNext = PH_HISET;
          else                             phaseNext = PH_ALE1;
        end
      end
      PH_HISET:  phaseNext = PH_ALE1;
      PH_ALE1:   phaseNext = PH_ALE2;
      PH_ALE2:   phaseNext = PH_LOHOLD;
      PH_LOHOLD: phaseNext = PH_STB1;
      PH_STB1:   phaseNext = PH_STB2;
      PH_STB2:   phaseNext = stretch ? PH_STB2 : PH_RECOV;
      PH_RECOV:  phaseNext = PH_IDLE;
      PH_INTACK: phaseNext = PH_IDLE;
      default:   phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      kindQ <= KIND_FETCH;
    end else begin
      phase <= phaseNext;
      if (phase == PH_IDLE && reqValid) kindQ <= reqKind;
    end
  end

  always_comb begin
    logic inStb;
    inStb          = (phase == PH_STB1) || (phase == PH_STB2);
    ctl            = '0;
    ctl.latchReq   = (phase == PH_IDLE) && reqValid;
    ctl.aleOn      = (phase == PH_ALE1) || (phase == PH_ALE2);
    ctl.driveLo    = ctl.aleOn || (phase == PH_LOHOLD);
    ctl.psenOn     = inStb && isFetchQ;
    ctl.wrOn       = inStb && isWriteQ;
    ctl.rdOn       = inStb && isDataQ && !isWriteQ;
    ctl.driveWr    = isWriteQ && (inStb || (phase == PH_RECOV));
    ctl.sampleRd   = (phase == PH_STB2) && !isWriteQ && !stretch;
    ctl.doneOn     = (phase == PH_RECOV) || (phase == PH_INTACK);
    ctl.internalOn = (phase == PH_INTACK);
  end

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STB2 && isDataQ && waitIn) |=> (ctl.rdOn || ctl.wrOn)); // R6
  AST_FETCH_NOWAIT: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_STB2 && isFetchQ) |=> (phase == PH_RECOV)); // R6
  AST_INT_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.internalOn |-> $past(reqReady)); // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.aleOn || ctl.psenOn || ctl.rdOn || ctl.wrOn) |-> !reqReady); // R9

endmodule

// File: rtl/mux_bus_dpath.sv
module mux_bus_dpath
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8,
  localparam int HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [HI_W-1:0]   addrHi,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  output logic              rspDone,
  output logic              rspInternal,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ, rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.latchReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (ctl.sampleRd) rdataQ <= adIn;
    end
  end

  assign addrHi      = addrQ[ADDR_W-1:DATA_W];
  assign adOut       = ctl.driveLo ? addrQ[DATA_W-1:0] : wdataQ;
  assign adOe        = ctl.driveLo || ctl.driveWr;
  assign ale         = ctl.aleOn;
  assign psenN       = !ctl.psenOn;
  assign rdN         = !ctl.rdOn;
  assign wrN         = !ctl.wrOn;
  assign rspDone     = ctl.doneOn;
  assign rspInternal = ctl.internalOn;
  assign rspData     = rdataQ;

  AST_ALE_TWO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ale) |=> (ale ##1 !ale)); // R3
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ale) |-> (adOe && adOut == $past(adOut))); // R3
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ale) |=> !(psenN && rdN && wrN)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({!psenN, !rdN, !wrN})); // R4
  AST_HI_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!psenN || !rdN || !wrN) |-> $stable(addrHi)); // R5
  AST_READ_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (!psenN || !rdN) |-> !adOe); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R8

endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mux_bus_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int INT_BITS = 16,
  localparam int HI_W    = ADDR_W - DATA_W,
  localparam int TOP_W   = ADDR_W - INT_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              progSel,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspDone,
  output logic              rspInternal,
  output logic [DATA_W-1:0] rspData,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [HI_W-1:0]   addrHi,
  output logic              ale,
  output logic              psenN,
  output logic              rdN,
  output logic              wrN,
  input  logic              waitIn
);

  busCtl_t ctl;

  mux_bus_fsm #(.TOP_W(TOP_W)) u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .progSel    (progSel),
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqAddrTop (reqAddr[ADDR_W-1:INT_BITS]),
    .waitIn     (waitIn),
    .reqReady   (reqReady),
    .ctl        (ctl)
  );

  mux_bus_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .reqAddr     (reqAddr),
    .reqWdata    (reqWdata),
    .adIn        (adIn),
    .adOut       (adOut),
    .adOe        (adOe),
    .addrHi      (addrHi),
    .ale         (ale),
    .psenN       (psenN),
    .rdN         (rdN),
    .wrN         (wrN),
    .rspDone     (rspDone),
    .rspInternal (rspInternal),
    .rspData     (rspData)
  );

endmodule

// File: tb/mux_bus_ctrl_bench.sv
module mux_bus_ctrl_bench;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic progSel = 1'b1;
  logic reqValid = 1'b0;
  logic [1:0] reqKind = 2'b00;
  logic [19:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic [7:0] adIn = '0;
  logic waitIn = 1'b0;
  logic reqReady, rspDone, rspInternal, adOe, ale, psenN, rdN, wrN;
  logic [7:0] rspData, adOut;
  logic [11:0] addrHi;

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  mux_bus_ctrl u_mux_bus_ctrl (
    .clk(clk), .rstN(rstN), .progSel(progSel), .reqValid(reqValid),
    .reqReady(reqReady), .reqKind(reqKind), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .rspDone(rspDone), .rspInternal(rspInternal),
    .rspData(rspData), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .addrHi(addrHi), .ale(ale), .psenN(psenN), .rdN(rdN), .wrN(wrN),
    .waitIn(waitIn)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(reqReady == 1'b1, "R1", "ready", reqReady, 1);
    chk(ale == 1'b0, "R1", "ale", ale, 0);
    chk({psenN, rdN, wrN} == 3'b111, "R1", "strobes", {psenN, rdN, wrN}, 3'b111);
    chk(adOe == 1'b0, "R1", "adOe", adOe, 0);
    chk(rspDone == 1'b0, "R1", "done", rspDone, 0);
  endtask

  // One access, recorded and checked tick by tick after the accepting edge.
  task automatic doAccess(input logic [1:0] kind, input logic [19:0] addr,
                          input logic [7:0] wd, input logic [7:0] rb,
                          input int waitT, input logic pinSel);
    bit isFetch, isWr, isInt, inStb, lo, wph;
    int b, w, rcv, last;
    isFetch = (kind == 2'b00);
    isWr    = (kind == 2'b10);
    isInt   = isFetch && pinSel && (addr[19:16] == 4'h0);
    b       = isFetch ? 1 : 0;
    w       = isFetch ? 0 : waitT;
    rcv     = isInt ? 1 : 6 + b + w;
    last    = rcv + 2;
    @(negedge clk);
    chk(reqReady, "R9", "ready before request", reqReady, 1);
    progSel = pinSel; reqValid = 1'b1; reqKind = kind; reqAddr = addr;
    reqWdata = wd; adIn = ~rb; waitIn = 1'b0;
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
      if (isInt) begin
        chk(rspDone == (i == 1), "R2", "internal done", rspDone, i == 1);
        if (i == 1) chk(rspInternal, "R2", "internal flag", rspInternal, 1);
        chk(!ale && psenN && rdN && wrN && !adOe, "R2", "bus quiet",
            {ale, psenN, rdN, wrN, adOe}, 5'b01110);
      end else begin
        inStb = (i >= 4 + b) && (i <= 5 + b + w);
        lo    = (i >= 1 + b) && (i <= 3 + b);
        wph   = isWr && (i >= 4 + b) && (i <= rcv);
        chk(ale == ((i == 1 + b) || (i == 2 + b)), "R3", $sformatf("ale t%0d", i),
            ale, (i == 1 + b) || (i == 2 + b));
        if (lo) chk(adOe && adOut == addr[7:0], "R3", $sformatf("low addr t%0d", i),
                    {adOe, adOut}, {1'b1, addr[7:0]});
        chk(psenN == !(inStb && isFetch), "R4", $sformatf("psenN t%0d", i),
            psenN, !(inStb && isFetch));
        chk(wrN == !(inStb && isWr), "R4", $sformatf("wrN t%0d", i),
            wrN, !(inStb && isWr));
        chk(rdN == !(inStb && !isFetch && !isWr), "R6", $sformatf("rdN t%0d", i),
            rdN, !(inStb && !isFetch && !isWr));
        if (i <= rcv) chk(addrHi == addr[19:8], "R5", $sformatf("addrHi t%0d", i),
                          addrHi, addr[19:8]);
        if (wph) chk(adOe && adOut == wd, "R7", $sformatf("write lane t%0d", i),
                     {adOe, adOut}, {1'b1, wd});
        if (!lo && !wph) chk(!adOe, "R8", $sformatf("lane released t%0d", i), adOe, 0);
        chk(rspDone == (i == rcv), "R8", $sformatf("done t%0d", i), rspDone, i == rcv);
        if (i == rcv && !isWr) chk(rspData == rb, "R8", "read byte", rspData, rb);
        chk(reqReady == (i > rcv), "R9", $sformatf("ready t%0d", i), reqReady, i > rcv);
      end
      // inputs for cycle i
      adIn   = (i == 5 + b + w) ? rb : ~rb;
      waitIn = (waitT > 0) && (i >= 5 + b) && (i <= 4 + b + waitT);
    end
    waitIn = 1'b0;
  endtask

  task automatic t_holdoff();
    @(negedge clk);
    reqValid = 1'b1; reqKind = 2'b01; reqAddr = 20'h4D2C1; progSel = 1'b0;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    chk(!reqReady, "R9", "busy not ready", reqReady, 0);
    reqValid = 1'b1; reqKind = 2'b10; reqAddr = 20'h77777;
    @(negedge clk);
    reqValid = 1'b0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      if (i >= 6) chk(!ale && wrN, "R9", $sformatf("no extra cycle %0d", i),
                      {ale, wrN}, 2'b01);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    doAccess(2'b00, 20'h0ABCD, 8'h00, 8'h11, 0, 1'b1);  // R2 internal
    doAccess(2'b00, 20'h2A5C3, 8'h00, 8'hA5, 0, 1'b1);  // R2 external above boundary
    doAccess(2'b00, 20'h01234, 8'h00, 8'h5A, 0, 1'b0);  // R2 pin low
    doAccess(2'b01, 20'h5F0E7, 8'h00, 8'h96, 0, 1'b1);  // R8 read
    doAccess(2'b10, 20'h8C31B, 8'h3C, 8'h00, 0, 1'b1);  // R7 write
    doAccess(2'b01, 20'hE2468, 8'h00, 8'hC3, 3, 1'b1);  // R6 read stretched
    doAccess(2'b10, 20'h13579, 8'hE1, 8'h00, 2, 1'b1);  // R6 write stretched
    doAccess(2'b00, 20'h9BDF0, 8'h00, 8'h6E, 2, 1'b1);  // R6 fetch ignores wait
    doAccess(2'b11, 20'h30F0F, 8'h00, 8'h48, 0, 1'b1);  // R4 kind 11 as read
    t_holdoff();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule